// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer Decoder for Tapped-Delay Edge Timing

This block turns one sampled word from a bank of sixteen delay taps into a fine-time code. Every tap carries the same input signal, each delayed a little more than the one before. When an edge lands inside a clock period, the taps with shorter delays have already switched and the longer ones have not. The registered word therefore reads as a run of one value followed by a run of the other. The bit where the run ends gives the arrival time of the edge, in sixteenths of the clock period. The result is good to within one tap step.

Tap bit 0 has the shortest delay. A polarity input selects which edge is measured. For a rising edge the word starts with ones at bit 0. For a falling edge the word is inverted first, so one locator serves both polarities. Before the boundary is located, each interior bit is replaced by the majority vote of itself and its two neighbours. This repairs a single wrong bit near the boundary. A word that still shows more than one boundary after this repair is reported as an error and produces no code.

Top module: `bubble_therm_decoder`

## Requirements
- R1: While rstN is low, codeValid and codeError are 0 and fineCode is 0.
- R2: A word counts as an edge candidate only when its bit 0 differs from its bit 15 and bit 0 equals the selected polarity (bit 0 = 1 when fallEdge = 0, bit 0 = 0 when fallEdge = 1). For any other word, codeValid and codeError are both 0 in the following cycle, and fineCode keeps its previous value.
- R3: With fallEdge = 1, the word is bitwise inverted before decoding. A falling word therefore gives the same fineCode as its complement gives with fallEdge = 0.
- R4: A clean rising word with ones in bits 0..k and zeros in bits k+1..15 (k from 0 to 14) gives fineCode = k with codeValid = 1.
- R5: Each interior bit i (1 to 14) is replaced by the majority of bits i-1, i and i+1, and bits 0 and 15 are left unchanged. fineCode is the highest index of the ones run that starts at bit 0 in the corrected word. For example, 0x005F gives 5.
- R6: If the corrected word has more than one place where neighbouring bits differ, codeError = 1 and codeValid = 0 in the following cycle, and fineCode keeps its previous value.
- R7: Outputs follow the sample taken at the previous rising clock edge, so latency is one cycle. codeValid is high for exactly one cycle per decoded candidate word, and is low in a cycle after a non-candidate word.
- R8: codeValid and codeError are never high in the same cycle.
- R9: fineCode changes only in a cycle where codeValid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the sample is taken on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleWord | input | 16 | Registered tap word; bit 0 has the shortest delay |
| fallEdge | input | 1 | 0 measures rising edges, 1 measures falling edges |
| fineCode | output | 4 | Boundary position in sixteenths of the clock period |
| codeValid | output | 1 | One-cycle pulse: fineCode holds a new decoded edge time |
| codeError | output | 1 | One-cycle pulse: the candidate word could not be decoded |

## Verification
Clean thermometer words at every boundary position from 0 to 14 show whether the locator counts to the right bit, including both ends of the range. Words with one flipped bit beside the boundary check that the majority vote pulls the code back to within one step. Words with a second, separated run check that the vote gives up and raises the error instead. Flat words, and words whose run has the wrong polarity, check that nothing is reported and that fineCode holds; complemented words with fallEdge set must reproduce the rising codes. Seeded random words, some clean, some with one flipped bit and some fully random, are compared against a bench model after these directed cases.

// File: rtl/therm_pkg.sv
package therm_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic loadCode;
    logic raiseValid;
    logic raiseError;
  } dec_strobe_t;

endpackage

// File: rtl/therm_datapath.sv
module therm_datapath
  import therm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int CODE_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  sampleWord,
  input  logic              fallEdge,
  input  dec_strobe_t       strobes,
  output logic              edgeOk,
  output logic              singleBound,
  output logic [CODE_W-1:0] codeQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0]  normWord;
  logic [WIDTH-1:0]  fixedWord;
  logic [WIDTH-2:0]  edgeMap;
  logic [CODE_W-1:0] locCode;
  logic              found;

  // Fold the falling polarity onto the rising one.
  assign normWord = fallEdge ? ~sampleWord : sampleWord;
  assign edgeOk   = normWord[0] & ~normWord[LAST];

  // Three-bit majority repair of interior bits; the end bits stay as sampled.
  assign fixedWord[0]    = normWord[0];
  assign fixedWord[LAST] = normWord[LAST];
  for (genvar i = 1; i < LAST; i++) begin : g_vote
    assign fixedWord[i] = (normWord[i-1] & normWord[i])
                        | (normWord[i]   & normWord[i+1])
                        | (normWord[i-1] & normWord[i+1]);
  end

  // Mark every neighbour pair that differs.
  for (genvar i = 0; i < LAST; i++) begin : g_bound
    assign edgeMap[i] = fixedWord[i] ^ fixedWord[i+1];
  end

  assign singleBound = $onehot(edgeMap);

  // The first differing pair ends the run that starts at bit 0.
  always_comb begin
    locCode = '0;
    found   = 1'b0;
    for (int i = 0; i < LAST; i++) begin
      if (!found && edgeMap[i]) begin
        locCode = CODE_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
    end else if (strobes.loadCode) begin
      codeQ <= locCode;
    end
  end

  // R4/R5: a loaded code always points inside the tap range.
  a_r4_code_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCode |=> (int'(codeQ) <= WIDTH - 2));

endmodule

// File: rtl/therm_control.sv
module therm_control
  import therm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        edgeOk,
  input  logic        singleBound,
  output dec_strobe_t strobes,
  output logic        validQ,
  output logic        errorQ
);

  always_comb begin
    strobes            = '0;
    strobes.loadCode   = edgeOk & singleBound;
    strobes.raiseValid = edgeOk & singleBound;
    strobes.raiseError = edgeOk & ~singleBound;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      errorQ <= 1'b0;
    end else begin
      validQ <= strobes.raiseValid;
      errorQ <= strobes.raiseError;
    end
  end

  // R8: a word is either decoded or rejected, never both.
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(validQ && errorQ));

  // R6: an error follows only from a candidate word.
  a_r6_error_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    errorQ |-> $past(edgeOk));

endmodule

// File: rtl/bubble_therm_decoder.sv
module bubble_therm_decoder
  import therm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int CODE_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  sampleWord,
  input  logic              fallEdge,
  output logic [CODE_W-1:0] fineCode,
  output logic              codeValid,
  output logic              codeError
);

  dec_strobe_t strobes;
  logic        edgeOk;
  logic        singleBound;

  therm_datapath #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleWord (sampleWord),
    .fallEdge   (fallEdge),
    .strobes    (strobes),
    .edgeOk     (edgeOk),
    .singleBound(singleBound),
    .codeQ      (fineCode)
  );

  therm_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .edgeOk     (edgeOk),
    .singleBound(singleBound),
    .strobes    (strobes),
    .validQ     (codeValid),
    .errorQ     (codeError)
  );

  // R1: reset clears the flags.
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!codeValid && !codeError));

  // R2: a word with equal end bits produces no report.
  a_r2_flat_word_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (sampleWord[0] == sampleWord[WIDTH-1]) |=> (!codeValid && !codeError));

  // R7: a valid pulse always traces back to an edge in the previous sample.
  a_r7_valid_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(sampleWord[0] != sampleWord[WIDTH-1]));

  // R9: the code moves only together with a valid pulse.
  a_r9_code_holds: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> (fineCode == $past(fineCode)));

endmodule

// File: tb/bubble_therm_decoder_bench.sv
module bubble_therm_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sampleWord = 16'h0000;
  logic        fallEdge = 1'b0;
  logic [3:0]  fineCode;
  logic        codeValid;
  logic        codeError;

  int   checks = 0;
  int   fails = 0;
  logic [3:0] expCode = 4'd0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bubble_therm_decoder u_bubble_therm_decoder (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord), .fallEdge(fallEdge),
    .fineCode(fineCode), .codeValid(codeValid), .codeError(codeError)
  );

  // Expected behaviour computed from the requirements.
  function automatic void model(input logic [15:0] w, input logic f,
                                output logic v, output logic e, output logic [3:0] c);
    logic [15:0] n;
    logic [15:0] m;
    int diffs;
    int ones;
    n = f ? ~w : w;
    v = 1'b0; e = 1'b0; c = 4'd0;
    if (n[0] == 1'b1 && n[15] == 1'b0) begin
      m = n;
      for (int i = 1; i < 15; i++)
        m[i] = (int'(n[i-1]) + int'(n[i]) + int'(n[i+1])) >= 2;
      diffs = 0; ones = 0;
      for (int i = 0; i < 15; i++) if (m[i] != m[i+1]) diffs++;
      for (int i = 0; i < 16; i++) if (m[i]) ones++;
      if (diffs == 1) begin v = 1'b1; c = 4'(ones - 1); end
      else e = 1'b1;
    end
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a word at a falling edge, check one clock later.
  task automatic apply(input logic [15:0] w, input logic f, input string req);
    logic v, e;
    logic [3:0] c;
    @(negedge clk);
    sampleWord = w;
    fallEdge = f;
    model(w, f, v, e, c);
    if (v) expCode = c;
    @(negedge clk);
    check(req, "codeValid", int'(codeValid), int'(v));
    check(req, "codeError", int'(codeError), int'(e));
    check(req, "fineCode", int'(fineCode), int'(expCode));
    check("R8", "flags exclusive", int'(codeValid && codeError), 0);
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R1", "codeValid in reset", int'(codeValid), 0);
    check("R1", "codeError in reset", int'(codeError), 0);
    check("R1", "fineCode in reset", int'(fineCode), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: every clean boundary position.
    for (int k = 0; k < 15; k++) apply(16'((32'h1 << (k + 1)) - 1), 1'b0, "R4");
    // R7: pulse drops after a flat word.
    apply(16'h0000, 1'b0, "R7");
    apply(16'h00FF, 1'b0, "R7");
    apply(16'h00FF, 1'b0, "R7");
    apply(16'hFFFF, 1'b0, "R7");
    // R2: flat words and wrong polarity leave code unchanged.
    apply(16'hFFFF, 1'b1, "R2");
    apply(16'hFF00, 1'b0, "R2");
    apply(16'h00FF, 1'b1, "R2");
    // R3: falling words match their rising complements.
    apply(~16'h003F, 1'b1, "R3");
    apply(~16'h7FFF, 1'b1, "R3");
    apply(~16'h005F, 1'b1, "R3");
    // R5: bubbles next to the boundary.
    apply(16'h005F, 1'b0, "R5");
    apply(16'h0005, 1'b0, "R5");
    apply(16'h00EF, 1'b0, "R5");
    apply(16'h5FFF, 1'b0, "R5");
    // R6: a second run survives the vote.
    apply(16'h0033, 1'b0, "R6");
    apply(16'h0F0F, 1'b0, "R6");
    apply(~16'h0333, 1'b1, "R6");

    // Random mix: clean, one flipped bit, or arbitrary.
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      logic f;
      int kind, k;
      kind = int'($urandom_range(2, 0));
      k = int'($urandom_range(14, 0));
      f = 1'($urandom_range(1, 0));
      w = 16'((32'h1 << (k + 1)) - 1);
      if (kind == 1) w[$urandom_range(14, 1)] ^= 1'b1;
      if (kind == 2) w = 16'($urandom);
      if (f) w = ~w;
      apply(w, f, kind == 2 ? "R6" : "R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule